// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host that writes 32-bit dwords and a bank of 128-bit control registers and 64-bit SRAM words. Wide targets cannot be written in one host access, so the block holds the dwords it has seen for one target in a collector. When the last missing dword arrives, it presents the assembled value to the target as a single full-width commit. Plain 32-bit registers bypass the collector and commit at once.

Per-queue registers repeat in pages of 0x2000 bytes. In every page, two write-only descriptor-pointer registers follow special rules. A write to their top dword always commits, and any lower part the collector does not hold is committed as zero. A write to a lower dword of such a register is dropped while the collector is busy with another target. A further quirk can be switched on by parameter: a write to the timer-command register of page 0 empties the collector.

Top module: `wide_wr_collector`

## Requirements
- R1: After reset the commit strobe is low and the collector is empty, so no dword written before reset can reach a later commit.
- R2: A write to an ordinary 128-bit register (any CSR address below 0xC000 that is not special) commits only after all four dwords of the same 16-byte-aligned address are held, in any order. The commit appears in the cycle after the last write: strobe high for one cycle, address aligned to 16, and dword k of the data taken from the write whose address bits [3:2] equal k.
- R3: Addresses at or above 0xC000 are 64-bit SRAM words. A word commits after both of its dwords are held (address bit 2 selects the dword), with an 8-aligned address and data bits [127:64] zero.
- R4: A dword write to a different wide target while a partial value is held discards the old partial value, and the collector restarts with the new target.
- R5: Writes to page offsets 0x400 and 0x420 commit in the next cycle with the data zero-extended and the dword address. They leave the collector unchanged, except as stated in R9.
- R6: A write to the top dword (page offset 0x83C or 0xA1C) of a descriptor-pointer register commits in the next cycle at the 16-aligned register address. Its lower dwords come from the collector if it holds that register and are zero otherwise. The collector is then empty.
- R7: A write to a lower dword of a descriptor-pointer register (offsets 0x830 to 0x838, 0xA10 to 0xA18) produces no commit. It is discarded, leaving the collector unchanged, when the collector holds a different target.
- R8: Page offsets are the low 13 address bits, so the special registers are recognised in every page (page n starts at n * 0x2000).
- R9: With the quirk enabled (the default), a write to offset 0x420 of page 0 empties the collector. The same offset in other pages does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host dword write in this cycle |
| wr_addr | input | 16 | Host byte address of the dword |
| wr_data | input | 32 | Host write data |
| cmt_valid | output | 1 | One-cycle commit strobe |
| cmt_addr | output | 16 | Aligned address of the committed target |
| cmt_data | output | 128 | Full-width commit data |

## Verification
Two functions can meet in one write: completing a held value and clearing the collector. A descriptor-pointer top-dword write that lands while the collector holds a different register must commit zeros in the low lanes and also throw the partial value away. A page-0 timer write must commit itself and also clear the collector. The bench sets up a three-dword partial value and then issues each of these writes. It judges the result from the commit data of that cycle and from the absence of a commit when the old register's last dword arrives later. In contrast, the same timer offset in page 1 and a plain register write must leave that partial value able to complete.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
   typedef enum logic [2:0] {
      K_WIDE     = 3'd0,
      K_SRAM     = 3'd1,
      K_PLAIN    = 3'd2,
      K_DESC_LO  = 3'd3,
      K_DESC_TOP = 3'd4
   } wkind_e;
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
   import wwc_pkg::*;
#(
   parameter int AW = 16,
   parameter int PAGE_BITS = 13,
   parameter int LW = 2,
   parameter int DB = 2,
   parameter int SB = 3,
   parameter int WB = 4,
   parameter logic [AW-1:0] SRAM_BASE = 16'hC000,
   parameter logic [PAGE_BITS-1:0] DESC_A_OFS = 13'h830,
   parameter logic [PAGE_BITS-1:0] DESC_B_OFS = 13'ha10,
   parameter logic [PAGE_BITS-1:0] PLAIN_OFS = 13'h400,
   parameter logic [PAGE_BITS-1:0] TIMER_OFS = 13'h420,
   parameter bit QUIRK_EN = 1'b1
) (
   input  logic [AW-1:0]    addr,
   output wkind_e           kind,
   output logic [AW-SB-1:0] tag,
   output logic [LW-1:0]    lane,
   output logic             timer0
);
   logic                 is_sram, is_desc, is_plain, is_top, timer_ofs;
   logic [PAGE_BITS-1:0] ofs;

   assign ofs       = addr[PAGE_BITS-1:0];
   assign is_sram   = addr >= SRAM_BASE;
   assign is_desc   = !is_sram && ((ofs[PAGE_BITS-1:WB] == DESC_A_OFS[PAGE_BITS-1:WB]) ||
                                   (ofs[PAGE_BITS-1:WB] == DESC_B_OFS[PAGE_BITS-1:WB]));
   assign timer_ofs = ofs[PAGE_BITS-1:DB] == TIMER_OFS[PAGE_BITS-1:DB];
   assign is_plain  = !is_sram && (timer_ofs || (ofs[PAGE_BITS-1:DB] == PLAIN_OFS[PAGE_BITS-1:DB]));
   assign is_top    = &addr[WB-1:DB];

   generate
      if (QUIRK_EN) begin : g_quirk
         assign timer0 = !is_sram && timer_ofs && (addr[AW-1:PAGE_BITS] == '0);
      end else begin : g_noquirk
         assign timer0 = 1'b0;
      end
   endgenerate

   always_comb begin
      if (is_sram) begin
         kind = K_SRAM;
         tag  = addr[AW-1:SB];
         lane = LW'(addr[SB-1:DB]);
      end else begin
         if (is_plain)     kind = K_PLAIN;
         else if (is_desc) kind = is_top ? K_DESC_TOP : K_DESC_LO;
         else              kind = K_WIDE;
         tag  = {addr[AW-1:WB], {(WB-SB){1'b0}}};
         lane = addr[WB-1:DB];
      end
   end
endmodule

// File: rtl/wwc_lanes.sv
module wwc_lanes #(
   parameter int DW = 32,
   parameter int LANES = 4,
   parameter int LW = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [LW-1:0]      wr_lane,
   input  logic [DW-1:0]      wr_data,
   input  logic [LANES-1:0]   keep_mask,
   output logic [LANES*DW-1:0] merged
);
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [DW-1:0] store_q;
         logic          hit;
         assign hit = wr_lane == LW'(i);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        store_q <= '0;
            else if (we && hit) store_q <= wr_data;
         end
         assign merged[i*DW +: DW] = hit ? wr_data : (keep_mask[i] ? store_q : '0);
      end
   endgenerate
endmodule

// File: rtl/wide_wr_collector.sv
module wide_wr_collector
   import wwc_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int WIDE_W = 128,
   parameter int SRAM_W = 64,
   parameter int PAGE_BITS = 13,
   parameter logic [AW-1:0] SRAM_BASE = 16'hC000,
   parameter logic [PAGE_BITS-1:0] DESC_A_OFS = 13'h830,
   parameter logic [PAGE_BITS-1:0] DESC_B_OFS = 13'ha10,
   parameter logic [PAGE_BITS-1:0] PLAIN_OFS = 13'h400,
   parameter logic [PAGE_BITS-1:0] TIMER_OFS = 13'h420,
   parameter bit QUIRK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic              cmt_valid,
   output logic [AW-1:0]     cmt_addr,
   output logic [WIDE_W-1:0] cmt_data
);
   localparam int LANES      = WIDE_W / DW;
   localparam int SRAM_LANES = SRAM_W / DW;
   localparam int LW         = $clog2(LANES);
   localparam int DB         = $clog2(DW / 8);
   localparam int SB         = $clog2(SRAM_W / 8);
   localparam int WB         = $clog2(WIDE_W / 8);
   localparam int TW         = AW - SB;

   generate
      if (WIDE_W % DW != 0 || SRAM_W % DW != 0 || SRAM_W >= WIDE_W)
         begin : g_bad_width
            $error("wide_wr_collector: widths must be dword multiples with SRAM narrower than CSR");
         end
      if (PAGE_BITS >= AW || PAGE_BITS <= WB) begin : g_bad_page
         $error("wide_wr_collector: page size out of range");
      end
   endgenerate

   wkind_e           kind;
   logic [TW-1:0]    tag_w, tag_q;
   logic [LW-1:0]    lane_w;
   logic             timer0;
   logic [LANES-1:0] mask_q, keep, next_mask, cur_bit;
   logic             held, same, full, store, commit, clear;
   logic [WIDE_W-1:0] merged, cdata_d;
   logic [AW-1:0]    caddr_d;

   wwc_decode #(
      .AW(AW), .PAGE_BITS(PAGE_BITS), .LW(LW), .DB(DB), .SB(SB), .WB(WB),
      .SRAM_BASE(SRAM_BASE), .DESC_A_OFS(DESC_A_OFS), .DESC_B_OFS(DESC_B_OFS),
      .PLAIN_OFS(PLAIN_OFS), .TIMER_OFS(TIMER_OFS), .QUIRK_EN(QUIRK_EN)
   ) u_dec (
      .addr(wr_addr), .kind(kind), .tag(tag_w), .lane(lane_w), .timer0(timer0)
   );

   wwc_lanes #(.DW(DW), .LANES(LANES), .LW(LW)) u_lanes (
      .clk(clk), .rst_n(rst_n), .we(store), .wr_lane(lane_w),
      .wr_data(wr_data), .keep_mask(keep), .merged(merged)
   );

   assign held      = |mask_q;
   assign same      = held && (tag_q == tag_w);
   assign keep      = same ? mask_q : '0;
   assign cur_bit   = LANES'(1) << lane_w;
   assign next_mask = keep | cur_bit;

   always_comb begin
      full    = 1'b0;
      store   = 1'b0;
      commit  = 1'b0;
      clear   = 1'b0;
      cdata_d = merged;
      caddr_d = {tag_w, {SB{1'b0}}};
      if (wr_valid) begin
         unique case (kind)
            K_PLAIN: begin
               commit  = 1'b1;
               clear   = timer0;
               cdata_d = {{(WIDE_W-DW){1'b0}}, wr_data};
               caddr_d = {wr_addr[AW-1:DB], {DB{1'b0}}};
            end
            K_DESC_TOP: begin
               commit = 1'b1;
               clear  = 1'b1;
            end
            K_DESC_LO: store = !held || same;
            K_SRAM: begin
               full   = &next_mask[SRAM_LANES-1:0];
               commit = full;
               clear  = full;
               store  = !full;
            end
            default: begin
               full   = &next_mask;
               commit = full;
               clear  = full;
               store  = !full;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         tag_q     <= '0;
         cmt_valid <= 1'b0;
         cmt_addr  <= '0;
         cmt_data  <= '0;
      end else begin
         cmt_valid <= commit;
         if (commit) begin
            cmt_addr <= caddr_d;
            cmt_data <= cdata_d;
         end
         if (clear) begin
            mask_q <= '0;
            tag_q  <= '0;
         end else if (store) begin
            mask_q <= next_mask;
            tag_q  <= tag_w;
         end
      end
   end
endmodule

// File: rtl/wwc_checker.sv
module wwc_checker #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int WIDE_W = 128,
   parameter logic [AW-1:0] SRAM_BASE = 16'hC000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [AW-1:0]     wr_addr,
   input logic [DW-1:0]     wr_data,
   input logic              cmt_valid,
   input logic [AW-1:0]     cmt_addr,
   input logic [WIDE_W-1:0] cmt_data
);
   logic        csr, sram, plain, dtop, dlo;
   logic [11:0] o;
   assign o     = {wr_addr[12:4], 3'b000} >> 0;
   assign csr   = wr_addr < SRAM_BASE;
   assign sram  = !csr;
   assign plain = csr && (wr_addr[12:2] == 11'h100 || wr_addr[12:2] == 11'h108);
   assign dtop  = csr && (wr_addr[12:0] == 13'h83c || wr_addr[12:0] == 13'ha1c);
   assign dlo   = csr && !dtop && (wr_addr[12:4] == 9'h083 || wr_addr[12:4] == 9'h0a1);

   p_commit_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid |-> $past(wr_valid));

   p_plain_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && plain |=> cmt_valid && cmt_data == {{(WIDE_W-DW){1'b0}}, $past(wr_data)});

   p_desc_top_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && dtop |=> cmt_valid && cmt_data[WIDE_W-1 -: DW] == $past(wr_data)
                           && cmt_addr == {$past(wr_addr[AW-1:4]), 4'h0});

   p_sram_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && sram |=> !cmt_valid || cmt_data[WIDE_W-1:64] == '0);

   p_desc_lo_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && dlo |=> !cmt_valid);
endmodule

bind wide_wr_collector wwc_checker #(
   .AW(AW), .DW(DW), .WIDE_W(WIDE_W), .SRAM_BASE(SRAM_BASE)
) u_wwc_checker (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
   .wr_data(wr_data), .cmt_valid(cmt_valid), .cmt_addr(cmt_addr), .cmt_data(cmt_data)
);

// File: tb/wide_wr_collector_bench.sv
`timescale 1ns/1ps
module wide_wr_collector_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic [15:0]  wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic         cmt_valid;
   logic [15:0]  cmt_addr;
   logic [127:0] cmt_data;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   logic         gv;
   logic [15:0]  ga;
   logic [127:0] gd;

   always #2 clk = ~clk;

   wide_wr_collector u_wide_wr_collector (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .cmt_valid(cmt_valid), .cmt_addr(cmt_addr), .cmt_data(cmt_data)
   );

   function automatic logic [31:0] dat(input logic [15:0] base, input int lane);
      return {8'h5A, base, 6'd0, 2'(lane)};
   endfunction

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_addr  = a;
      wr_data  = d;
      @(negedge clk);
      gv = cmt_valid;
      ga = cmt_addr;
      gd = cmt_data;
      wr_valid = 1'b0;
   endtask

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic no_commit(input string req);
      chk(gv == 1'b0, req, {127'd0, gv}, 128'd0);
   endtask

   task automatic commit_is(input string req, input logic [15:0] a, input logic [127:0] d);
      chk(gv == 1'b1, {req, " strobe"}, {127'd0, gv}, 128'd1);
      chk(ga == a, {req, " addr"}, {112'd0, ga}, {112'd0, a});
      chk(gd == d, {req, " data"}, gd, d);
   endtask

   task automatic partial3(input logic [15:0] base);
      for (int k = 0; k < 3; k++) wr(base + 16'(4*k), dat(base, k));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1: no commit out of reset
      chk(cmt_valid == 1'b0, "R1 reset strobe", {127'd0, cmt_valid}, 128'd0);
      // R1: empty collector, so a lone descriptor top commits zero low lanes
      wr(16'h083c, 32'hCAFE0001);
      commit_is("R1 empty collector", 16'h0830, {32'hCAFE0001, 96'd0});

      // R2 / R8: every CSR page, every rotation of the dword order
      for (int pg = 0; pg < 6; pg++) begin
         for (int rot = 0; rot < 4; rot++) begin
            logic [15:0] base;
            base = 16'(pg * 16'h2000 + 16'h0100 + rot * 16);
            for (int k = 0; k < 4; k++) begin
               int ln;
               ln = (rot + k) % 4;
               wr(base + 16'(4*ln), dat(base, ln));
               if (k < 3) no_commit("R2 early commit");
            end
            commit_is("R2 full commit", base,
                      {dat(base, 3), dat(base, 2), dat(base, 1), dat(base, 0)});
         end
      end

      // R3: SRAM words, both dword orders
      for (int w = 0; w < 8; w++) begin
         logic [15:0] a;
         a = 16'hC000 + 16'(w * 8);
         if (w % 2 == 1) begin
            wr(a + 16'd4, dat(a, 1)); no_commit("R3 early commit");
            wr(a, dat(a, 0));
         end else begin
            wr(a, dat(a, 0)); no_commit("R3 early commit");
            wr(a + 16'd4, dat(a, 1));
         end
         commit_is("R3 sram commit", a, {64'd0, dat(a, 1), dat(a, 0)});
      end

      // R4: interleaving discards old partial
      wr(16'h0200, dat(16'h0200, 0));
      wr(16'h0204, dat(16'h0200, 1));
      for (int k = 0; k < 4; k++) wr(16'h2300 + 16'(4*k), dat(16'h2300, k));
      commit_is("R4 new target commit", 16'h2300,
                {dat(16'h2300, 3), dat(16'h2300, 2), dat(16'h2300, 1), dat(16'h2300, 0)});
      wr(16'h0208, dat(16'h0200, 2));
      wr(16'h020c, dat(16'h0200, 3));
      no_commit("R4 discarded partial");

      // R5: plain register commits at once and keeps the partial value
      partial3(16'h0500);
      wr(16'h4400, 32'h1234ABCD);
      commit_is("R5 plain commit", 16'h4400, {96'd0, 32'h1234ABCD});
      wr(16'h050c, dat(16'h0500, 3));
      commit_is("R5 collector kept", 16'h0500,
                {dat(16'h0500, 3), dat(16'h0500, 2), dat(16'h0500, 1), dat(16'h0500, 0)});

      // R9: timer command in page 1 leaves the collector alone
      partial3(16'h0600);
      wr(16'h2420, 32'h0000_0077);
      commit_is("R9 page1 timer commit", 16'h2420, {96'd0, 32'h0000_0077});
      wr(16'h060c, dat(16'h0600, 3));
      commit_is("R9 page1 keeps collector", 16'h0600,
                {dat(16'h0600, 3), dat(16'h0600, 2), dat(16'h0600, 1), dat(16'h0600, 0)});
      // R9: timer command in page 0 clears the collector
      partial3(16'h0700);
      wr(16'h0420, 32'h0000_0055);
      commit_is("R9 page0 timer commit", 16'h0420, {96'd0, 32'h0000_0055});
      wr(16'h070c, dat(16'h0700, 3));
      no_commit("R9 collector cleared");

      // R6 / R8: lone descriptor tops in each page, both registers
      for (int pg = 0; pg < 6; pg++) begin
         logic [15:0] pb;
         pb = 16'(pg * 16'h2000);
         wr(pb + 16'h0a1c, 32'hD0000000 | 32'(pg));
         commit_is("R8 desc B top", pb + 16'h0a10, {32'hD0000000 | 32'(pg), 96'd0});
      end
      // R6: partial descriptor lanes merged, missing lane zero
      wr(16'h6830, 32'h11111111); no_commit("R7 desc low no commit");
      wr(16'h6834, 32'h22222222); no_commit("R7 desc low no commit");
      wr(16'h683c, 32'h44444444);
      commit_is("R6 desc merge", 16'h6830, {32'h44444444, 32'd0, 32'h22222222, 32'h11111111});
      // R6: top while collector holds another register: zeros, collector emptied
      partial3(16'h0800);
      wr(16'h2a1c, 32'h99999999);
      commit_is("R6 desc over other", 16'h2a10, {32'h99999999, 96'd0});
      wr(16'h080c, dat(16'h0800, 3));
      no_commit("R6 collector emptied");

      // R7: lower descriptor write dropped while another target held
      wr(16'h0900, dat(16'h0900, 0));
      wr(16'h2a14, 32'hBAD0BAD0);
      no_commit("R7 dropped write");
      wr(16'h0904, dat(16'h0900, 1));
      wr(16'h0908, dat(16'h0900, 2));
      wr(16'h090c, dat(16'h0900, 3));
      commit_is("R7 collector unchanged", 16'h0900,
                {dat(16'h0900, 3), dat(16'h0900, 2), dat(16'h0900, 1), dat(16'h0900, 0)});
      wr(16'h2a1c, 32'h77777777);
      commit_is("R7 dropped lane not kept", 16'h2a10, {32'h77777777, 96'd0});

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule